// File: doc/BRIEF.md
# Data Register Store Sequencer

This block holds the sixteen six-bit stored settings of a dual wiper and dual comparator-control device: four channels (channel 0 and 1 are the wipers, 2 and 3 the comparator-control registers), each with four register slots. A command decoder hands it store requests: write a host value into one slot, copy one channel's live value into one of its slots, or copy all four live values into the same slot number of every channel. The request is only armed when the frame is received. It is committed when chip select returns high. Once committed, a busy (write-in-process) flag covers a programmable number of clock cycles that stands in for the cell programming time. The new contents become visible when that window ends.

Writes are gated by an active-low write-protect input, which is sampled at the commit point. Requests that arrive during a write cycle are dropped. Reads see the previous contents until the cycle completes. The block also drives the transfer source (one slot of every channel) and the power-up recall values (slot 0 of every channel). A one-cycle recall strobe follows reset. A move from a slot into a live register uses only the read side and never starts a write cycle.

The sequencer has three states. IDLE goes to ARMED on an accepted request. ARMED goes back to IDLE when the decoder cancels the frame, or when chip select rises while write protect is low (the request is discarded). ARMED goes to BUSY when chip select rises with write protect high. BUSY goes to IDLE when the store timer expires, and the staged contents are written at that point.

Top module: `nvstore_seq`

## Requirements
- R1: After reset, wip and status_byte are 0, every slot reads INIT_WORD, and recall_load is 1 for exactly the first clock cycle after reset release.
- R2: A write request (req_kind 0) armed by req_valid is committed on the first rising edge of cs_n. wip is 1 in the cycle after cs_n is first seen high, and afterwards the addressed slot reads req_data.
- R3: wip stays 1 for exactly WRITE_CYCLES consecutive cycles per committed store.
- R4: status_byte is seven zero bits followed by wip in bit 0.
- R5: A request followed by req_cancel before cs_n rises writes nothing and never raises wip.
- R6: If wp_n is 0 when cs_n rises, the armed request is discarded: wip stays 0 and no slot changes.
- R7: A single-store request (req_kind 1) copies live_vec segment req_chan into slot req_reg of that channel only.
- R8: A global store (req_kind 2) copies all four live_vec segments into slot req_reg of every channel in one write cycle.
- R9: Requests and chip-select cycles that occur while wip is 1 are ignored: no later write cycle and no slot change results.
- R10: While wip is 1, rd_data returns the slot's previous contents. The new contents appear only when wip falls.
- R11: recall_vec always shows slot 0 of every channel and src_vec shows slot src_reg of every channel. Using them starts no write cycle.
- R12: A rise of cs_n with no armed request starts no write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select, active low; its rising edge commits |
| wp_n | input | 1 | Write protect, active low |
| req_valid | input | 1 | One-cycle strobe from the decoder: complete store request |
| req_kind | input | 2 | 0 write slot, 1 store one live value, 2 store all live values, 3 none |
| req_chan | input | 2 | Target channel |
| req_reg | input | 2 | Target slot |
| req_data | input | 6 | Host data for kind 0 |
| req_cancel | input | 1 | Frame broken before chip select rose |
| live_vec | input | 24 | Live wiper and control values, channel c at bits 6c+5..6c |
| rd_chan | input | 2 | Read channel |
| rd_reg | input | 2 | Read slot |
| rd_data | output | 6 | Stored contents of the read slot |
| src_reg | input | 2 | Slot used as transfer source |
| src_vec | output | 24 | Slot src_reg of each channel |
| recall_vec | output | 24 | Slot 0 of each channel |
| recall_load | output | 1 | One-cycle strobe after reset to load recall_vec |
| status_byte | output | 8 | Status byte, write-in-process in bit 0 |
| wip | output | 1 | Write cycle in progress |

## Verification
The assertions check on every cycle that a busy window opens only after a chip-select rise with write protect high, that the window lasts exactly the configured length, that a held read address returns unchanged data through the window, and that the recall strobe is a single cycle. The bench scenarios are needed to show what ends up stored: which slots a single or global store touches, that protected, cancelled, unarmed and busy-time requests leave everything as it was, and that recall and source outputs follow the stored slots.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_BUSY  = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        REQ_WRITE     = 2'd0,
        REQ_STORE_ONE = 2'd1,
        REQ_STORE_ALL = 2'd2,
        REQ_NONE      = 2'd3
    } req_kind_e;
endpackage

// File: rtl/nvs_edge.sv
module nvs_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_n,
    output logic rise
);
    logic sig_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sig_q <= 1'b1;
        else        sig_q <= sig_n;
    end

    assign rise = sig_n & ~sig_q;
endmodule

// File: rtl/nvs_timer.sv
module nvs_timer #(
    parameter int WRITE_CYCLES = 500000,
    localparam int CNT_W = $clog2(WRITE_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= CNT_W'(WRITE_CYCLES - 1);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/nvs_array.sv
module nvs_array #(
    parameter int CHANNELS = 4,
    parameter int REGS     = 4,
    parameter int WORD_W   = 6,
    parameter logic [WORD_W-1:0] INIT_WORD = '0,
    localparam int CH_W = $clog2(CHANNELS),
    localparam int RG_W = $clog2(REGS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         commit,
    input  logic [CHANNELS-1:0]          mask,
    input  logic [RG_W-1:0]              wr_reg,
    input  logic [CHANNELS*WORD_W-1:0]   wr_vec,
    input  logic [CH_W-1:0]              rd_chan,
    input  logic [RG_W-1:0]              rd_reg,
    output logic [WORD_W-1:0]            rd_data,
    input  logic [RG_W-1:0]              src_reg,
    output logic [CHANNELS*WORD_W-1:0]   src_vec,
    output logic [CHANNELS*WORD_W-1:0]   recall_vec
);
    logic [WORD_W-1:0] mem [CHANNELS][REGS];

    for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
        for (genvar r = 0; r < REGS; r++) begin : g_slot
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    mem[c][r] <= INIT_WORD;
                else if (commit && mask[c] && wr_reg == RG_W'(r))
                    mem[c][r] <= wr_vec[c*WORD_W +: WORD_W];
            end
        end
        assign src_vec[c*WORD_W +: WORD_W]    = mem[c][src_reg];
        assign recall_vec[c*WORD_W +: WORD_W] = mem[c][0];
    end

    assign rd_data = mem[rd_chan][rd_reg];
endmodule

// File: rtl/nvstore_seq.sv
module nvstore_seq
    import nvs_pkg::*;
#(
    parameter int CHANNELS     = 4,
    parameter int REGS         = 4,
    parameter int WORD_W       = 6,
    parameter int WRITE_CYCLES = 500000,
    parameter logic [WORD_W-1:0] INIT_WORD = '0,
    localparam int CH_W = $clog2(CHANNELS),
    localparam int RG_W = $clog2(REGS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cs_n,
    input  logic                       wp_n,
    input  logic                       req_valid,
    input  logic [1:0]                 req_kind,
    input  logic [CH_W-1:0]            req_chan,
    input  logic [RG_W-1:0]            req_reg,
    input  logic [WORD_W-1:0]          req_data,
    input  logic                       req_cancel,
    input  logic [CHANNELS*WORD_W-1:0] live_vec,
    input  logic [CH_W-1:0]            rd_chan,
    input  logic [RG_W-1:0]            rd_reg,
    output logic [WORD_W-1:0]          rd_data,
    input  logic [RG_W-1:0]            src_reg,
    output logic [CHANNELS*WORD_W-1:0] src_vec,
    output logic [CHANNELS*WORD_W-1:0] recall_vec,
    output logic                       recall_load,
    output logic [7:0]                 status_byte,
    output logic                       wip
);
    seq_state_e state, state_nx;
    logic cs_rise, tmr_done;
    logic take_req, launch, finish;

    // pending request captured from the decoder
    req_kind_e          p_kind;
    logic [CH_W-1:0]    p_chan;
    logic [RG_W-1:0]    p_reg;
    logic [WORD_W-1:0]  p_data;

    // staged write applied when the busy window closes
    logic [CHANNELS-1:0]          s_mask;
    logic [CHANNELS*WORD_W-1:0]   s_vec;

    logic recall_seen;

    nvs_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sig_n (cs_n),
        .rise  (cs_rise)
    );

    nvs_timer #(.WRITE_CYCLES(WRITE_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (launch),
        .done  (tmr_done)
    );

    nvs_array #(
        .CHANNELS  (CHANNELS),
        .REGS      (REGS),
        .WORD_W    (WORD_W),
        .INIT_WORD (INIT_WORD)
    ) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (finish),
        .mask       (s_mask),
        .wr_reg     (p_reg),
        .wr_vec     (s_vec),
        .rd_chan    (rd_chan),
        .rd_reg     (rd_reg),
        .rd_data    (rd_data),
        .src_reg    (src_reg),
        .src_vec    (src_vec),
        .recall_vec (recall_vec)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (req_valid && req_kind != REQ_NONE) state_nx = ST_ARMED;
            ST_ARMED: begin
                if (req_cancel)   state_nx = ST_IDLE;
                else if (cs_rise) state_nx = wp_n ? ST_BUSY : ST_IDLE;
            end
            ST_BUSY:  if (tmr_done) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // outputs and strobes
    always_comb begin
        take_req = 1'b0;
        launch   = 1'b0;
        finish   = 1'b0;
        wip      = 1'b0;
        unique case (state)
            ST_IDLE:  take_req = req_valid && req_kind != REQ_NONE;
            ST_ARMED: launch   = !req_cancel && cs_rise && wp_n;
            ST_BUSY: begin
                wip    = 1'b1;
                finish = tmr_done;
            end
            default: ;
        endcase
        status_byte = {7'b0, wip};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_kind <= REQ_NONE;
            p_chan <= '0;
            p_reg  <= '0;
            p_data <= '0;
        end else if (take_req) begin
            p_kind <= req_kind_e'(req_kind);
            p_chan <= req_chan;
            p_reg  <= req_reg;
            p_data <= req_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_mask <= '0;
            s_vec  <= '0;
        end else if (launch) begin
            for (int c = 0; c < CHANNELS; c++) begin
                unique case (p_kind)
                    REQ_WRITE: begin
                        s_mask[c] <= (p_chan == CH_W'(c));
                        s_vec[c*WORD_W +: WORD_W] <= p_data;
                    end
                    REQ_STORE_ONE: begin
                        s_mask[c] <= (p_chan == CH_W'(c));
                        s_vec[c*WORD_W +: WORD_W] <= live_vec[c*WORD_W +: WORD_W];
                    end
                    REQ_STORE_ALL: begin
                        s_mask[c] <= 1'b1;
                        s_vec[c*WORD_W +: WORD_W] <= live_vec[c*WORD_W +: WORD_W];
                    end
                    default: s_mask[c] <= 1'b0;
                endcase
            end
        end
    end

    // recall strobe: first cycle after reset release
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            recall_seen <= 1'b0;
            recall_load <= 1'b0;
        end else begin
            recall_seen <= 1'b1;
            recall_load <= !recall_seen;
        end
    end
endmodule

// File: rtl/nvstore_seq_chk.sv
module nvstore_seq_chk #(
    parameter int CH_W         = 2,
    parameter int RG_W         = 2,
    parameter int WORD_W       = 6,
    parameter int WRITE_CYCLES = 500000,
    localparam int RUN_W = $clog2(WRITE_CYCLES + 2)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              wp_n,
    input logic              wip,
    input logic              recall_load,
    input logic [CH_W-1:0]   rd_chan,
    input logic [RG_W-1:0]   rd_reg,
    input logic [WORD_W-1:0] rd_data
);
    logic [RUN_W-1:0] run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   run <= '0;
        else if (wip) run <= run + 1'b1;
        else          run <= '0;
    end

    // R2 and R12: a write cycle opens only right after chip select rose
    assert_commit_on_cs_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> ($past(cs_n) && !$past(cs_n, 2)));

    // R6: write protect must be high at the commit point
    assert_wp_gates_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> $past(wp_n));

    // R3: busy window never longer than configured
    assert_busy_not_long_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wip |-> (run < RUN_W'(WRITE_CYCLES)));

    // R3: busy window exactly the configured length
    assert_busy_exact_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wip) |-> (run == RUN_W'(WRITE_CYCLES)));

    // R10: stored data stays old while the write cycle runs
    assert_old_data_in_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wip && $past(wip) && $stable(rd_chan) && $stable(rd_reg)) |-> $stable(rd_data));

    // R1: recall strobe lasts a single cycle
    assert_recall_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        recall_load |=> !recall_load);
endmodule

bind nvstore_seq nvstore_seq_chk #(
    .CH_W         (CH_W),
    .RG_W         (RG_W),
    .WORD_W       (WORD_W),
    .WRITE_CYCLES (WRITE_CYCLES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .wp_n        (wp_n),
    .wip         (wip),
    .recall_load (recall_load),
    .rd_chan     (rd_chan),
    .rd_reg      (rd_reg),
    .rd_data     (rd_data)
);

// File: tb/nvstore_seq_test.sv
module nvstore_seq_test;
    localparam int WC = 12;
    localparam logic [5:0] INIT = 6'h2A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, wp_n = 1'b1;
    logic req_valid = 1'b0, req_cancel = 1'b0;
    logic [1:0] req_kind = 2'd3, req_chan = '0, req_reg = '0, rd_chan = '0, rd_reg = '0, src_reg = '0;
    logic [5:0] req_data = '0, rd_data;
    logic [23:0] live_vec = '0, src_vec, recall_vec;
    logic recall_load, wip;
    logic [7:0] status_byte;

    int checks = 0, errors = 0;
    logic [5:0] model [4][4];

    always #10 clk = ~clk;

    nvstore_seq #(.WRITE_CYCLES(WC), .INIT_WORD(INIT)) uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n),
        .req_valid(req_valid), .req_kind(req_kind), .req_chan(req_chan),
        .req_reg(req_reg), .req_data(req_data), .req_cancel(req_cancel),
        .live_vec(live_vec), .rd_chan(rd_chan), .rd_reg(rd_reg), .rd_data(rd_data),
        .src_reg(src_reg), .src_vec(src_vec), .recall_vec(recall_vec),
        .recall_load(recall_load), .status_byte(status_byte), .wip(wip)
    );

    // entry: kind[12:11] chan[10:9] slot[8:7] data[6:1] wp[0]
    localparam logic [12:0] VECS [8] = '{
        {2'd0, 2'd0, 2'd1, 6'h05, 1'b1},
        {2'd0, 2'd3, 2'd3, 6'h3F, 1'b1},
        {2'd1, 2'd1, 2'd2, 6'h00, 1'b1},
        {2'd2, 2'd0, 2'd3, 6'h00, 1'b1},
        {2'd0, 2'd2, 2'd0, 6'h11, 1'b0},
        {2'd2, 2'd0, 2'd0, 6'h00, 1'b0},
        {2'd0, 2'd2, 2'd0, 6'h00, 1'b1},
        {2'd1, 2'd3, 2'd1, 6'h00, 1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic frame(input logic [1:0] k, input logic [1:0] ch, input logic [1:0] rg,
                         input logic [5:0] d, input logic wp, input logic cancel);
        @(negedge clk); cs_n = 1'b0; wp_n = wp;
        @(negedge clk); req_valid = 1'b1; req_kind = k; req_chan = ch; req_reg = rg; req_data = d;
        @(negedge clk); req_valid = 1'b0; req_kind = 2'd3; req_cancel = cancel;
        @(negedge clk); req_cancel = 1'b0; cs_n = 1'b1;
    endtask

    task automatic busy_len(output int len);
        len = 0;
        @(negedge clk);
        if (wip) chk("R4 status in busy", 32'(status_byte), 32'h01);
        while (wip && len < 4 * WC) begin
            len++;
            @(negedge clk);
        end
        chk("R4 status idle", 32'(status_byte), 32'h00);
    endtask

    task automatic check_all(input string tag);
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++) begin
                rd_chan = 2'(c); rd_reg = 2'(r); #1;
                chk(tag, 32'(rd_data), 32'(model[c][r]));
            end
    endtask

    task automatic idle_for(input string tag, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(tag, 32'(wip), 32'd0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        int len;
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++) model[c][r] = INIT;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state and recall strobe
        @(negedge clk);
        chk("R1 recall_load first cycle", 32'(recall_load), 32'd1);
        chk("R1 wip after reset", 32'(wip), 32'd0);
        @(negedge clk);
        chk("R1 recall_load second cycle", 32'(recall_load), 32'd0);
        chk("R1 status after reset", 32'(status_byte), 32'd0);
        check_all("R1 init contents");

        // table walk: R2 write, R7 single store, R8 global store, R6 protect, R3 length
        for (int i = 0; i < 8; i++) begin
            logic [1:0] k, ch, rg;
            logic [5:0] d;
            logic wp;
            {k, ch, rg, d, wp} = VECS[i];
            for (int c = 0; c < 4; c++)
                live_vec[c*6 +: 6] = 6'(i * 7 + c * 11 + 3);
            frame(k, ch, rg, d, wp, 1'b0);
            busy_len(len);
            chk("R3 R6 busy length", 32'(len), wp ? 32'(WC) : 32'd0);
            if (wp) begin
                case (k)
                    2'd0: model[ch][rg] = d;
                    2'd1: model[ch][rg] = live_vec[ch*6 +: 6];
                    default: for (int c = 0; c < 4; c++) model[c][rg] = live_vec[c*6 +: 6];
                endcase
            end
            check_all("R2 R6 R7 R8 contents");
        end

        // R5 cancelled frame
        frame(2'd0, 2'd1, 2'd0, 6'h33, 1'b1, 1'b1);
        idle_for("R5 cancel no wip", 3);
        check_all("R5 cancel contents");

        // R12 chip-select cycle with nothing armed
        @(negedge clk); cs_n = 1'b0;
        @(negedge clk); cs_n = 1'b1;
        idle_for("R12 bare cs no wip", 3);

        // R10 old data during busy, R9 request during busy
        frame(2'd0, 2'd0, 2'd2, 6'h1B, 1'b1, 1'b0);
        @(negedge clk);
        chk("R10 busy started", 32'(wip), 32'd1);
        rd_chan = 2'd0; rd_reg = 2'd2; #1;
        chk("R10 old contents in busy", 32'(rd_data), 32'(model[0][2]));
        frame(2'd0, 2'd0, 2'd3, 6'h07, 1'b1, 1'b0);
        chk("R9 still busy", 32'(wip), 32'd1);
        rd_chan = 2'd0; rd_reg = 2'd2; #1;
        chk("R10 old contents late busy", 32'(rd_data), 32'(model[0][2]));
        while (wip) @(negedge clk);
        model[0][2] = 6'h1B;
        idle_for("R9 no second write", 3);
        check_all("R9 R10 contents after busy");

        // R11 recall and source outputs, no write cycle from reading them
        for (int r = 0; r < 4; r++) begin
            @(negedge clk); src_reg = 2'(r); #1;
            for (int c = 0; c < 4; c++)
                chk("R11 src_vec", 32'(src_vec[c*6 +: 6]), 32'(model[c][r]));
        end
        for (int c = 0; c < 4; c++)
            chk("R11 recall_vec", 32'(recall_vec[c*6 +: 6]), 32'(model[c][0]));
        idle_for("R11 no write from transfer read", 2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule